// File: doc/BRIEF.md
# Digital Slope Ramp Generator

This block produces the code word for a comparator reference DAC as a digital ramp. A run starts from a programmable start value and moves toward a programmable end value. Each move is one signed step of programmable size. The moves come at an update rate set by a divider with an integer part and a 5-bit fractional part. The lower limit and the upper limit are separate configuration fields. In rising mode the ramp climbs from the lower limit to the upper limit. In falling mode it descends from the upper limit to the lower limit.

A run can be started in three ways. Firmware can start it directly. An external hardware trigger or a timer terminal-count event can also start it, and each of these two has its own enable. Once a run reaches its end value, it either stops and holds that value, or in continuous mode it reloads the start value on the next update and keeps going. A one-cycle strobe accompanies every change of the output code, so a downstream DAC latch or a comparator sequencer knows when a new code is present. All start requests pass through one register stage, so a run starts two clock edges after the request is sampled.

Top module: `slope_ramp_gen`

## Requirements
- R1: Synchronous reset (`rst` high) forces `dac_code` to 0 and `dac_upd` to 0, stops any run and clears the divider and its fractional accumulator. This holds even when a run is in progress.
- R2: A start request loads the start value into `dac_code` on the second rising edge after it is sampled. `sw_start` always counts as a request. `hw_trig` counts only when `cfg_hw_en` is 1, and `tmr_tc` counts only when `cfg_tc_en` is 1. A gated trigger leaves `dac_code` and `dac_upd` unchanged.
- R3: Direction encoding: `cfg_dir` = 0 selects rising and 1 selects falling. In rising mode the start value is `cfg_lim_lo`, and each update tick raises the code by `cfg_step`.
- R4: A rising step that would reach or pass `cfg_lim_hi` sets the code to exactly `cfg_lim_hi`. The code never wraps, and during a run it stays between the two limits.
- R5: In falling mode the start value is `cfg_lim_hi`. Each tick lowers the code by `cfg_step`, and the code saturates at `cfg_lim_lo`.
- R6: With `cfg_cont` = 0 the run stops on the tick that reaches the end value. After that the code holds and no strobe occurs until a new start request.
- R7: With `cfg_cont` = 1, the tick after the code reaches the end value reloads the start value. The ramp repeats with no further start request.
- R8: The first tick comes `cfg_int` cycles after the start value is loaded. Each later period lasts `cfg_int` cycles, plus one extra cycle whenever adding `cfg_frac` to a 5-bit accumulator overflows. The accumulator starts at 0 on each start. Over 32 periods the total is 32·`cfg_int` + `cfg_frac` cycles. A `cfg_int` of 0 behaves as 1.
- R9: `dac_upd` is high for exactly those cycles in which `dac_code` differs from its value in the previous cycle.
- R10: A start request during a run reloads the start value and restarts the divider, so the next step follows a full `cfg_int`-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lim_lo | input | CODE_W | Lower ramp limit |
| cfg_lim_hi | input | CODE_W | Upper ramp limit |
| cfg_step | input | STEP_W | Step size per update |
| cfg_dir | input | 1 | 0 = rising, 1 = falling |
| cfg_cont | input | 1 | 1 = repeat continuously |
| cfg_int | input | INT_W | Integer part of update period, in clocks |
| cfg_frac | input | FRAC_W | Fractional part of update period, in 1/32 clock |
| cfg_hw_en | input | 1 | Enable for hw_trig as a start source |
| cfg_tc_en | input | 1 | Enable for tmr_tc as a start source |
| sw_start | input | 1 | Firmware start pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| tmr_tc | input | 1 | Timer terminal-count pulse |
| dac_code | output | CODE_W | Ramp code to the DAC |
| dac_upd | output | 1 | One-cycle strobe on each code change |

## Verification
The hardest condition to reach is the fractional stretch of the update period. The extra cycle appears only on periods where the accumulator overflows, so its pattern only becomes visible across many ticks. The stimulus measures the gap between successive strobes with a fraction of one half, where gaps must alternate between the integer part and one more. It then runs 32 periods with an integer part of 11 and a fraction of 23, and compares the total elapsed cycles with 32·11 + 23. A second hard case is a restart that lands in the middle of a divider period. It is reached by issuing a firmware start one cycle after a strobe, then checking that both the code and the next strobe spacing start over.

// File: rtl/slope_ramp_pkg.sv
package slope_ramp_pkg;

   typedef enum logic {
      RAMP_UP   = 1'b0,
      RAMP_DOWN = 1'b1
   } ramp_dir_e;

   localparam int unsigned ACC_BITS_MIN = 1;

endpackage

// File: rtl/slope_ramp_trig.sv
module slope_ramp_trig #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic hw_en,
   input  logic tc_en,
   input  logic sw_start,
   input  logic hw_trig,
   input  logic tmr_tc,
   output logic start
);

   logic hw_s;
   logic tc_s;
   logic req;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign hw_s = hw_trig;
         assign tc_s = tmr_tc;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] hw_q;
         logic [SYNC_STAGES-1:0] tc_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               hw_q <= '0;
               tc_q <= '0;
            end else begin
               hw_q <= {hw_q[SYNC_STAGES-1:0] , hw_trig} >> 0;
               tc_q <= {tc_q[SYNC_STAGES-1:0] , tmr_tc} >> 0;
            end
         end
         assign hw_s = hw_q[SYNC_STAGES-1];
         assign tc_s = tc_q[SYNC_STAGES-1];
      end
   endgenerate

   assign req = sw_start | (hw_en & hw_s) | (tc_en & tc_s);

   always_ff @(posedge clk) begin
      if (rst) start <= 1'b0;
      else     start <= req;
   end

endmodule

// File: rtl/slope_ramp_rate.sv
module slope_ramp_rate #(
   parameter int unsigned INT_W  = 8,
   parameter int unsigned FRAC_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              restart,
   input  logic              run,
   input  logic [INT_W-1:0]  intg,
   input  logic [FRAC_W-1:0] frac,
   output logic              tick
);

   localparam int unsigned CW = INT_W + 1;

   logic [CW-1:0]     cnt;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   acc_sum;
   logic              carry;
   logic [INT_W-1:0]  intg_eff;
   logic [CW-1:0]     last_cnt;

   assign acc_sum  = {1'b0, acc} + {1'b0, frac};
   assign carry    = acc_sum[FRAC_W];
   assign intg_eff = (intg == '0) ? INT_W'(1) : intg;
   assign last_cnt = {1'b0, intg_eff} - CW'(1) + {{INT_W{1'b0}}, carry};
   assign tick     = run & ~restart & (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         cnt <= '0;
         acc <= '0;
      end else if (tick) begin
         cnt <= '0;
         acc <= acc_sum[FRAC_W-1:0];
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/slope_ramp_step.sv
module slope_ramp_step
   import slope_ramp_pkg::*;
#(
   parameter int unsigned CODE_W = 10,
   parameter int unsigned STEP_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              tick,
   input  logic [CODE_W-1:0] lim_lo,
   input  logic [CODE_W-1:0] lim_hi,
   input  logic [STEP_W-1:0] step,
   input  logic              dir,
   input  logic              cont,
   output logic [CODE_W-1:0] code,
   output logic              upd,
   output logic              run
);

   localparam int unsigned XW = CODE_W + 1;

   ramp_dir_e         dir_e;
   logic [XW-1:0]     step_x;
   logic [XW-1:0]     up_sum;
   logic [XW-1:0]     lo_plus;
   logic [CODE_W-1:0] up_val;
   logic [CODE_W-1:0] dn_val;
   logic [CODE_W-1:0] first_val;
   logic [CODE_W-1:0] final_val;
   logic [CODE_W-1:0] moved_val;
   logic [CODE_W-1:0] code_n;
   logic              run_n;

   assign dir_e   = ramp_dir_e'(dir);
   assign step_x  = {{(XW-STEP_W){1'b0}}, step};
   assign up_sum  = {1'b0, code} + step_x;
   assign lo_plus = {1'b0, lim_lo} + step_x;
   assign up_val  = (up_sum >= {1'b0, lim_hi}) ? lim_hi : up_sum[CODE_W-1:0];
   assign dn_val  = ({1'b0, code} <= lo_plus) ? lim_lo : (code - step_x[CODE_W-1:0]);

   always_comb begin
      if (dir_e == RAMP_DOWN) begin
         first_val = lim_hi;
         final_val = lim_lo;
         moved_val = dn_val;
      end else begin
         first_val = lim_lo;
         final_val = lim_hi;
         moved_val = up_val;
      end
   end

   always_comb begin
      code_n = code;
      run_n  = run;
      if (start) begin
         code_n = first_val;
         run_n  = 1'b1;
      end else if (run && tick) begin
         if (code == final_val) begin
            if (cont) code_n = first_val;
            else      run_n  = 1'b0;
         end else begin
            code_n = moved_val;
            if (!cont && moved_val == final_val) run_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code <= '0;
         upd  <= 1'b0;
         run  <= 1'b0;
      end else begin
         code <= code_n;
         upd  <= (code_n != code);
         run  <= run_n;
      end
   end

endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen
   import slope_ramp_pkg::*;
#(
   parameter int unsigned CODE_W      = 10,
   parameter int unsigned STEP_W      = 10,
   parameter int unsigned INT_W       = 8,
   parameter int unsigned FRAC_W      = 5,
   parameter int unsigned TRIG_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] cfg_lim_lo,
   input  logic [CODE_W-1:0] cfg_lim_hi,
   input  logic [STEP_W-1:0] cfg_step,
   input  logic              cfg_dir,
   input  logic              cfg_cont,
   input  logic [INT_W-1:0]  cfg_int,
   input  logic [FRAC_W-1:0] cfg_frac,
   input  logic              cfg_hw_en,
   input  logic              cfg_tc_en,
   input  logic              sw_start,
   input  logic              hw_trig,
   input  logic              tmr_tc,
   output logic [CODE_W-1:0] dac_code,
   output logic              dac_upd
);

   generate
      if (STEP_W > CODE_W) begin : g_bad_step
         $error("slope_ramp_gen: STEP_W must not exceed CODE_W");
      end
      if (FRAC_W < ACC_BITS_MIN) begin : g_bad_frac
         $error("slope_ramp_gen: FRAC_W must be at least 1");
      end
      if (INT_W < 1 || CODE_W < 2) begin : g_bad_width
         $error("slope_ramp_gen: INT_W >= 1 and CODE_W >= 2 required");
      end
   endgenerate

   logic start_w;
   logic tick_w;
   logic run_w;

   slope_ramp_trig #(
      .SYNC_STAGES(TRIG_STAGES)
   ) u_trig (
      .clk      (clk),
      .rst      (rst),
      .hw_en    (cfg_hw_en),
      .tc_en    (cfg_tc_en),
      .sw_start (sw_start),
      .hw_trig  (hw_trig),
      .tmr_tc   (tmr_tc),
      .start    (start_w)
   );

   slope_ramp_rate #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
   ) u_rate (
      .clk     (clk),
      .rst     (rst),
      .restart (start_w),
      .run     (run_w),
      .intg    (cfg_int),
      .frac    (cfg_frac),
      .tick    (tick_w)
   );

   slope_ramp_step #(
      .CODE_W (CODE_W),
      .STEP_W (STEP_W)
   ) u_step (
      .clk    (clk),
      .rst    (rst),
      .start  (start_w),
      .tick   (tick_w),
      .lim_lo (cfg_lim_lo),
      .lim_hi (cfg_lim_hi),
      .step   (cfg_step),
      .dir    (cfg_dir),
      .cont   (cfg_cont),
      .code   (dac_code),
      .upd    (dac_upd),
      .run    (run_w)
   );

endmodule

// File: rtl/slope_ramp_chk.sv
module slope_ramp_chk #(
   parameter int unsigned CODE_W = 10,
   parameter int unsigned INT_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              tick,
   input logic              run,
   input logic [CODE_W-1:0] code,
   input logic              upd,
   input logic [CODE_W-1:0] lo,
   input logic [CODE_W-1:0] hi,
   input logic [INT_W-1:0]  intg
);

   localparam int unsigned GW = INT_W + 2;

   logic          rst_q;
   logic          past_ok;
   logic [GW-1:0] gap;
   logic [GW-1:0] per_min;

   assign per_min = (intg == '0) ? GW'(1) : GW'(intg);

   always_ff @(posedge clk) begin
      rst_q   <= rst;
      past_ok <= !rst;
      if (rst)                 gap <= '0;
      else if (start || tick)  gap <= GW'(1);
      else if (gap != '1)      gap <= gap + GW'(1);
      if (rst_q) begin
         assert_reset_clear_R1: assert (code == '0 && !upd)
            else $error("reset did not clear code/strobe");
      end
   end

   assert_upd_on_change_R9: assert property (@(posedge clk) disable iff (rst)
      (past_ok && code != $past(code)) |-> upd);

   assert_upd_only_change_R9: assert property (@(posedge clk) disable iff (rst)
      (past_ok && upd) |-> code != $past(code));

   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!run && !start) |=> $stable(code));

   assert_within_limits_R4: assert property (@(posedge clk) disable iff (rst)
      (run && lo <= hi) |-> (code >= lo && code <= hi));

   assert_period_bounds_R8: assert property (@(posedge clk) disable iff (rst)
      (tick && !start) |-> (gap >= per_min && gap <= per_min + GW'(1)));

endmodule

bind slope_ramp_gen slope_ramp_chk #(
   .CODE_W (CODE_W),
   .INT_W  (INT_W)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .start (start_w),
   .tick  (tick_w),
   .run   (run_w),
   .code  (dac_code),
   .upd   (dac_upd),
   .lo    (cfg_lim_lo),
   .hi    (cfg_lim_hi),
   .intg  (cfg_int)
);

// File: tb/sim_slope_ramp_gen.sv
`timescale 1ns/1ps
module sim_slope_ramp_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [9:0] cfg_lim_lo = '0;
   logic [9:0] cfg_lim_hi = '0;
   logic [9:0] cfg_step = '0;
   logic       cfg_dir = 1'b0;
   logic       cfg_cont = 1'b0;
   logic [7:0] cfg_int = 8'd1;
   logic [4:0] cfg_frac = '0;
   logic       cfg_hw_en = 1'b0;
   logic       cfg_tc_en = 1'b0;
   logic       sw_start = 1'b0;
   logic       hw_trig = 1'b0;
   logic       tmr_tc = 1'b0;
   logic [9:0] dac_code;
   logic       dac_upd;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   slope_ramp_gen u0 (
      .clk(clk), .rst(rst),
      .cfg_lim_lo(cfg_lim_lo), .cfg_lim_hi(cfg_lim_hi), .cfg_step(cfg_step),
      .cfg_dir(cfg_dir), .cfg_cont(cfg_cont), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
      .cfg_hw_en(cfg_hw_en), .cfg_tc_en(cfg_tc_en),
      .sw_start(sw_start), .hw_trig(hw_trig), .tmr_tc(tmr_tc),
      .dac_code(dac_code), .dac_upd(dac_upd)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      sw_start = 1'b0; hw_trig = 1'b0; tmr_tc = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic setcfg(int lo, int hi, int st, int dir, int cont, int ip, int fp);
      cfg_lim_lo = 10'(lo); cfg_lim_hi = 10'(hi); cfg_step = 10'(st);
      cfg_dir = 1'(dir); cfg_cont = 1'(cont); cfg_int = 8'(ip); cfg_frac = 5'(fp);
   endtask

   // src: 0 firmware, 1 hardware trigger, 2 timer terminal count
   task automatic fire(int src);
      if (src == 0) sw_start = 1'b1;
      else if (src == 1) hw_trig = 1'b1;
      else tmr_tc = 1'b1;
      @(negedge clk);
      sw_start = 1'b0; hw_trig = 1'b0; tmr_tc = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_upd(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!dac_upd && n < 5000);
   endtask

   task automatic quiet(string req, int cycles, int code_exp);
      int pulses = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (dac_upd) pulses++;
      end
      chk(req, "strobes while idle", pulses, 0);
      chk(req, "held code", dac_code, code_exp);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "code after reset", dac_code, 0);
      chk("R1", "strobe after reset", dac_upd, 0);
      setcfg(77, 1023, 1, 0, 0, 50, 0);
      fire(0);
      chk("R2", "firmware start load", dac_code, 77);
      do_reset();
      chk("R1", "code after mid-run reset", dac_code, 0);
      quiet("R1", 60, 0);
   endtask

   task automatic t_rise_oneshot();
      int n; int e;
      do_reset();
      setcfg(10, 40, 7, 0, 0, 3, 0);
      fire(0);
      chk("R3", "rising start value", dac_code, 10);
      chk("R9", "strobe on load", dac_upd, 1);
      e = 10;
      while (e != 40) begin
         wait_upd(n);
         e = (e + 7 >= 40) ? 40 : e + 7;
         chk("R8", "rising period", n, 3);
         chk((e == 40) ? "R4" : "R3", "rising code", dac_code, e);
      end
      quiet("R6", 20, 40);
      fire(0);
      chk("R6", "restart after end", dac_code, 10);
   endtask

   task automatic t_fall_oneshot();
      int n; int e;
      do_reset();
      setcfg(5, 30, 10, 1, 0, 2, 0);
      fire(0);
      chk("R5", "falling start value", dac_code, 30);
      e = 30;
      while (e != 5) begin
         wait_upd(n);
         e = (e <= 5 + 10) ? 5 : e - 10;
         chk("R8", "falling period", n, 2);
         chk("R5", "falling code", dac_code, e);
      end
      quiet("R6", 15, 5);
   endtask

   task automatic t_cont();
      int n; int e;
      do_reset();
      setcfg(100, 103, 1, 0, 1, 2, 0);
      fire(0);
      e = 100;
      for (int i = 0; i < 10; i++) begin
         wait_upd(n);
         e = (e == 103) ? 100 : e + 1;
         chk("R7", "continuous rising code", dac_code, e);
      end
      do_reset();
      setcfg(200, 260, 25, 1, 1, 1, 0);
      fire(0);
      e = 260;
      for (int i = 0; i < 6; i++) begin
         wait_upd(n);
         e = (e == 200) ? 260 : ((e <= 225) ? 200 : e - 25);
         chk("R7", "continuous falling code", dac_code, e);
         chk("R8", "period of one", n, 1);
      end
   endtask

   task automatic t_frac();
      int n; int tot;
      do_reset();
      setcfg(0, 1023, 1, 0, 1, 2, 16);
      fire(0);
      for (int i = 0; i < 6; i++) begin
         wait_upd(n);
         chk("R8", "half-fraction gap", n, (i % 2 == 0) ? 2 : 3);
      end
      do_reset();
      setcfg(0, 1023, 1, 0, 0, 11, 23);
      fire(0);
      tot = 0;
      for (int i = 0; i < 32; i++) begin
         wait_upd(n);
         tot += n;
      end
      chk("R8", "32-period total", tot, 32 * 11 + 23);
      chk("R3", "code after 32 steps", dac_code, 32);
      do_reset();
      setcfg(0, 1023, 3, 0, 0, 0, 0);
      fire(0);
      for (int i = 1; i <= 4; i++) begin
         wait_upd(n);
         chk("R8", "zero integer part gap", n, 1);
         chk("R3", "zero integer part code", dac_code, 3 * i);
      end
   endtask

   task automatic t_gate();
      do_reset();
      setcfg(50, 60, 1, 0, 0, 200, 0);
      cfg_hw_en = 1'b0; cfg_tc_en = 1'b0;
      fire(2);
      chk("R2", "gated timer event", dac_code, 0);
      chk("R2", "gated timer strobe", dac_upd, 0);
      fire(1);
      chk("R2", "gated hw trigger", dac_code, 0);
      chk("R2", "gated hw strobe", dac_upd, 0);
      cfg_hw_en = 1'b1;
      fire(1);
      chk("R2", "enabled hw trigger", dac_code, 50);
      do_reset();
      cfg_hw_en = 1'b0; cfg_tc_en = 1'b1;
      fire(2);
      chk("R2", "enabled timer event", dac_code, 50);
      cfg_tc_en = 1'b0;
   endtask

   task automatic t_restart();
      int n;
      do_reset();
      setcfg(0, 100, 5, 0, 0, 3, 0);
      fire(0);
      wait_upd(n);
      wait_upd(n);
      chk("R10", "code before restart", dac_code, 10);
      @(negedge clk);
      fire(0);
      chk("R10", "code reloaded", dac_code, 0);
      chk("R10", "strobe on reload", dac_upd, 1);
      wait_upd(n);
      chk("R10", "full period after restart", n, 3);
      chk("R10", "first step after restart", dac_code, 5);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_rise_oneshot();
      t_fall_oneshot();
      t_cont();
      t_frac();
      t_gate();
      t_restart();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule